// File: doc/BRIEF.md
# Shadow-Configured PWM Channel Bank

This block drives up to four independent pulse-width-modulated outputs. Each channel has one 32-bit control word on a simple memory-mapped bus. Inside each channel a phase accumulator of `BU_W` bits adds a programmable step on every clock and wraps. The step therefore sets the output frequency, which is the step times the clock rate divided by 2^`BU_W`. An 8-bit threshold compares against the top eight phase bits and so sets the duty cycle. A larger threshold gives a shorter high time: the output is high while the top phase byte is at or above the threshold.

Software writes the step and threshold into a shadow copy. That copy reaches the running channel only after a write that also sets the update-request bit. The channel then adopts the shadow values at the next wrap of its phase accumulator, which starts a new output cycle, and clears the request bit on its own. Software polls the request bit to see when the new settings are live. Any write made while a request is outstanding is dropped. The enable bit is not shadowed and acts on the output at once. Channels sit at a fixed 0x400-byte address stride.

Top module: `pwm_shadow_bank`

## Requirements
- R1: After reset every channel reads back as 0x0000_0000, every output is low and no update is pending.
- R2: The control word read back has enable at bit 31, the live update-pending flag at bit 30, the step at bits [8 +: BU_W] and the threshold at bits 7:0. All other bits read as zero.
- R3: With a power-of-two step `b`, the output period is 2^BU_W / b clock cycles.
- R4: Within a period the output is high on exactly the cycles where the top 8 bits of the phase are greater than or equal to the active threshold.
- R5: A write without bit 30 changes the shadow step and threshold but leaves the running output pattern unchanged.
- R6: A write with bit 30 set, accepted while no update is pending, makes bit 30 read 1. The shadow values become active at the next accumulator wrap, and bit 30 then reads 0, within one period.
- R7: While bit 30 reads 1, writes to that channel are ignored: the read-back word, the enable state and the values later committed are those of the write that raised the request.
- R8: Clearing bit 31 forces the output low from the clock after the write, and it stays low.
- R9: Channel n answers only at byte address n*0x400. Writes to any other offset change nothing, reads from it return zero, and a write to one channel leaves the others untouched.
- R10: When the active step is zero the accumulator is idle, so a requested update commits on the very next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pwm_out | output | NUM_CH | PWM outputs, one per channel |

## Verification
The hardest case to reach from the ports is a write that lands while an update is still outstanding. It has to be issued in the short window between the request and the next accumulator wrap. The bench therefore first runs a slow step of 64 cycles per period, raises a request and writes again at once. It then checks that both the read-back word and the pattern committed later belong to the first write. The idle-commit case needs a channel whose active step is still zero, so it is exercised on a channel untouched since reset. The duty rule is swept over all 256 thresholds at one step and over a grid of steps and thresholds, against counts worked out from phase arithmetic.

// File: rtl/pwm_shadow_pkg.sv
package pwm_shadow_pkg;

  localparam int WORD_W   = 32;
  localparam int EN_POS   = 31;
  localparam int REQ_POS  = 30;
  localparam int THR_W    = 8;
  localparam int STEP_LSB = 8;
  localparam int STEP_MAX = 22;

  // Assemble the read-back control word from its fields.
  function automatic logic [WORD_W-1:0] pack_word(
    input logic                en,
    input logic                req,
    input logic [STEP_MAX-1:0] step,
    input logic [THR_W-1:0]    thr
  );
    return {en, req, step, thr};
  endfunction

  // High phase of the output: top phase byte at or above the threshold.
  function automatic logic duty_high(
    input logic [THR_W-1:0] phase_top,
    input logic [THR_W-1:0] thr
  );
    return phase_top >= thr;
  endfunction

  // Mask of read-back bits that carry no field for a given step width.
  function automatic logic [WORD_W-1:0] spare_mask(input int step_w);
    logic [WORD_W-1:0] m;
    m = 32'h3FFF_FF00;
    for (int k = 0; k < STEP_MAX; k++) begin
      if (k < step_w) m[STEP_LSB + k] = 1'b0;
    end
    return m;
  endfunction

endpackage

// File: rtl/pwm_phase_acc.sv
module pwm_phase_acc #(
  parameter int BU_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [BU_W-1:0] step,
  output logic [BU_W-1:0] phase,
  output logic            wrap
);
  logic [BU_W:0] sum;

  always_comb begin
    sum  = {1'b0, phase} + {1'b0, step};
    wrap = sum[BU_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= '0;
    else        phase <= sum[BU_W-1:0];
  end
endmodule

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs
  import pwm_shadow_pkg::*;
#(
  parameter int BU_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wdata,
  input  logic              cycle_start,
  output logic              reg_en,
  output logic [BU_W-1:0]   reg_step,
  output logic [THR_W-1:0]  reg_thr,
  output logic              pending,
  output logic [BU_W-1:0]   act_step,
  output logic [THR_W-1:0]  act_thr,
  output logic              commit
);
  logic accept;

  assign accept = wr_en && !pending;
  assign commit = pending && cycle_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_en   <= 1'b0;
      reg_step <= '0;
      reg_thr  <= '0;
    end else if (accept) begin
      reg_en   <= wdata[EN_POS];
      reg_step <= wdata[STEP_LSB +: BU_W];
      reg_thr  <= wdata[THR_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         pending <= 1'b0;
    else if (commit)                    pending <= 1'b0;
    else if (accept && wdata[REQ_POS])  pending <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_step <= '0;
      act_thr  <= '0;
    end else if (commit) begin
      act_step <= reg_step;
      act_thr  <= reg_thr;
    end
  end
endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage
  import pwm_shadow_pkg::*;
#(
  parameter int BU_W = 10
) (
  input  logic             en,
  input  logic [BU_W-1:0]  phase,
  input  logic [THR_W-1:0] thr,
  output logic             out
);
  logic [THR_W-1:0] phase_top;

  assign phase_top = phase[BU_W-1 -: THR_W];
  assign out       = en && duty_high(phase_top, thr);
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_shadow_pkg::*;
#(
  parameter int BU_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] word,
  output logic              out,
  output logic              en,
  output logic              pending,
  output logic              cycle_start
);
  logic [BU_W-1:0]  reg_step, act_step, phase;
  logic [THR_W-1:0] reg_thr, act_thr;
  logic             wrap, commit;

  // A new output cycle begins on a wrap, or at once if the accumulator idles.
  assign cycle_start = wrap || (act_step == '0);

  pwm_cfg_regs #(.BU_W(BU_W)) u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wdata       (wdata),
    .cycle_start (cycle_start),
    .reg_en      (en),
    .reg_step    (reg_step),
    .reg_thr     (reg_thr),
    .pending     (pending),
    .act_step    (act_step),
    .act_thr     (act_thr),
    .commit      (commit)
  );

  pwm_phase_acc #(.BU_W(BU_W)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (act_step),
    .phase (phase),
    .wrap  (wrap)
  );

  pwm_out_stage #(.BU_W(BU_W)) u_out (
    .en    (en),
    .phase (phase),
    .thr   (act_thr),
    .out   (out)
  );

  assign word = pack_word(en, pending, STEP_MAX'(reg_step), reg_thr);
endmodule

// File: rtl/pwm_shadow_bank.sv
module pwm_shadow_bank
  import pwm_shadow_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int BU_W        = 10,
  parameter int STRIDE_LOG2 = 10,
  parameter int ADDR_W      = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NUM_CH-1:0] pwm_out
);
  logic [NUM_CH-1:0]        ch_hit, ch_en, ch_pend, ch_start;
  logic [NUM_CH*WORD_W-1:0] ch_word;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign ch_hit[i] = (bus_addr == ADDR_W'(i << STRIDE_LOG2));

    pwm_channel #(.BU_W(BU_W)) u_ch (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (bus_sel && bus_wr && ch_hit[i]),
      .wdata       (bus_wdata),
      .word        (ch_word[i*WORD_W +: WORD_W]),
      .out         (pwm_out[i]),
      .en          (ch_en[i]),
      .pending     (ch_pend[i]),
      .cycle_start (ch_start[i])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (ch_hit[i]) bus_rdata = bus_rdata | ch_word[i*WORD_W +: WORD_W];
    end
  end
endmodule

// File: rtl/pwm_shadow_bank_chk.sv
module pwm_shadow_bank_chk
  import pwm_shadow_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int BU_W   = 10
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NUM_CH-1:0]        ch_en,
  input logic [NUM_CH-1:0]        ch_pend,
  input logic [NUM_CH-1:0]        ch_start,
  input logic [NUM_CH*WORD_W-1:0] ch_word,
  input logic [NUM_CH-1:0]        pwm_out,
  input logic [31:0]              bus_rdata
);
  localparam logic [WORD_W-1:0] SPARE = spare_mask(BU_W);

  // R2: bits outside the defined fields read zero
  a_r2_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & SPARE) == '0);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    // R8: a disabled channel never drives high
    a_r8_off_low: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_en[i] |-> !pwm_out[i]);
    // R6: request drops at the cycle start
    a_r6_clear_at_start: assert property (@(posedge clk) disable iff (!rst_n)
      ch_pend[i] && ch_start[i] |=> !ch_pend[i]);
    // R6: request persists until a cycle start
    a_r6_hold_to_start: assert property (@(posedge clk) disable iff (!rst_n)
      ch_pend[i] && !ch_start[i] |=> ch_pend[i]);
    // R7: control fields frozen while a request is outstanding
    a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      ch_pend[i] |=> $stable({ch_word[i*WORD_W + 31], ch_word[i*WORD_W +: 30]}));
  end
endmodule

bind pwm_shadow_bank pwm_shadow_bank_chk #(.NUM_CH(NUM_CH), .BU_W(BU_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ch_en     (ch_en),
  .ch_pend   (ch_pend),
  .ch_start  (ch_start),
  .ch_word   (ch_word),
  .pwm_out   (pwm_out),
  .bus_rdata (bus_rdata)
);

// File: tb/pwm_shadow_bank_test.sv
module pwm_shadow_bank_test;
  localparam int NCH = 4;
  localparam int W   = 10;
  localparam int FULL = 1 << W;
  localparam logic [31:0] EN  = 32'h8000_0000;
  localparam logic [31:0] UPD = 32'h4000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NCH-1:0] pwm_out;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pwm_shadow_bank uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwm_out(pwm_out)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_sel = 1'b1; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0; bus_sel = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a; bus_sel = 1'b1; bus_wr = 1'b0;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  function automatic logic [31:0] cfg(input bit en, input int step, input int thr);
    return (en ? EN : 32'h0) | (32'(step) << 8) | 32'(thr);
  endfunction

  // Expected high cycles in one period, from phase arithmetic (R3/R4).
  function automatic int exp_high(input int step, input int thr);
    int p, n;
    p = FULL / step; n = 0;
    for (int k = 0; k < p; k++) if (((k * step) >> (W - 8)) >= thr) n++;
    return n;
  endfunction

  task automatic count_high(input int ch, input int cycles, output int n);
    n = 0;
    for (int k = 0; k < cycles; k++) begin
      if (pwm_out[ch]) n++;
      @(negedge clk);
    end
  endtask

  // Poll until the request bit clears; returns cycles waited.
  task automatic wait_commit(input logic [11:0] a, input int limit, output int waited);
    logic [31:0] d;
    waited = 0;
    rd(a, d);
    while (d[30] && waited < limit) begin
      @(negedge clk); waited++;
      rd(a, d);
    end
  endtask

  task automatic program_and_measure(input int step, input int thr, input int prev_p, input string req);
    int waited, n, p;
    logic [31:0] d;
    p = FULL / step;
    wr(12'h000, cfg(1, step, thr) | UPD);
    wait_commit(12'h000, prev_p + 4, waited);
    chk(waited <= prev_p + 1, "R6 commit within a period", waited, prev_p + 1);
    rd(12'h000, d);
    chk(d == cfg(1, step, thr), "R2 readback after commit", d, cfg(1, step, thr));
    count_high(0, p, n);
    chk(n == exp_high(step, thr), req, n, exp_high(step, thr));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int n, prev_p, t0, t1;
    int steps [4] = '{4, 16, 64, 256};
    int thrs [6] = '{0, 1, 50, 128, 200, 255};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int c = 0; c < NCH; c++) begin
      rd(12'(c << 10), d);
      chk(d == 32'h0, "R1 reset word", d, 0);
    end
    chk(pwm_out == '0, "R1 outputs low", pwm_out, 0);

    // R2: spare bits dropped, fields placed
    wr(12'h000, 32'h3FFC_0000 | EN);
    rd(12'h000, d);
    chk(d == EN, "R2 spare bits read zero", d, EN);

    // R5: shadow write without request; active step 0, threshold 0 -> steady high
    wr(12'h000, cfg(1, 64, 200));
    rd(12'h000, d);
    chk(d == cfg(1, 64, 200), "R5 shadow readback", d, cfg(1, 64, 200));
    count_high(0, 50, n);
    chk(n == 50, "R5 output pattern unchanged", n, 50);

    // R3/R4/R6 grid sweep
    prev_p = 1;
    foreach (steps[s]) begin
      foreach (thrs[t]) begin
        program_and_measure(steps[s], thrs[t], prev_p, "R4 high count grid");
        prev_p = FULL / steps[s];
      end
    end

    // R4: every threshold at step 128
    for (int t = 0; t < 256; t++) begin
      program_and_measure(128, t, prev_p, "R4 high count threshold sweep");
      prev_p = 8;
    end

    // R3: period between rising edges
    foreach (steps[s]) begin
      program_and_measure(steps[s], 128, prev_p, "R4 high count mid threshold");
      prev_p = FULL / steps[s];
      while (pwm_out[0]) @(negedge clk);
      while (!pwm_out[0]) @(negedge clk);
      t0 = $time / 20;
      while (pwm_out[0]) @(negedge clk);
      while (!pwm_out[0]) @(negedge clk);
      t1 = $time / 20;
      chk((t1 - t0) == prev_p, "R3 period", t1 - t0, prev_p);
    end

    // R7: second write while request outstanding is dropped
    program_and_measure(16, 128, prev_p, "R4 setup for R7");
    wr(12'h000, cfg(1, 16, 0) | UPD);
    rd(12'h000, d);
    chk(d == (cfg(1, 16, 0) | UPD), "R6 request visible", d, cfg(1, 16, 0) | UPD);
    wr(12'h000, cfg(0, 32, 255));
    rd(12'h000, d);
    chk(d == (cfg(1, 16, 0) | UPD), "R7 write ignored while pending", d, cfg(1, 16, 0) | UPD);
    wait_commit(12'h000, 70, n);
    rd(12'h000, d);
    chk(d == cfg(1, 16, 0), "R7 committed first write", d, cfg(1, 16, 0));
    count_high(0, 64, n);
    chk(n == 64, "R7 committed pattern of first write", n, 64);

    // R8: disable forces low
    wr(12'h000, cfg(0, 16, 0));
    chk(pwm_out[0] == 1'b0, "R8 low right after disable", pwm_out[0], 0);
    count_high(0, 64, n);
    chk(n == 0, "R8 stays low", n, 0);

    // R9: channel 1 independent; nonzero offset ignored
    wr(12'h400, cfg(1, 64, 128) | UPD);
    wait_commit(12'h400, 4, n);
    rd(12'h400, d);
    chk(d == cfg(1, 64, 128), "R9 channel 1 readback", d, cfg(1, 64, 128));
    rd(12'h000, d);
    chk(d == cfg(0, 16, 0), "R9 channel 0 untouched", d, cfg(0, 16, 0));
    count_high(1, 16, n);
    chk(n == exp_high(64, 128), "R9 channel 1 output", n, exp_high(64, 128));
    wr(12'h004, cfg(1, 1, 1));
    rd(12'h004, d);
    chk(d == 32'h0, "R9 nonzero offset reads zero", d, 0);
    rd(12'h000, d);
    chk(d == cfg(0, 16, 0), "R9 nonzero offset write ignored", d, cfg(0, 16, 0));
    rd(12'h800, d);
    chk(d == 32'h0, "R9 channel 2 untouched", d, 0);

    // R10: idle accumulator commits on the next clock (channel 3 untouched since reset)
    wr(12'hC00, cfg(1, 32, 0) | UPD);
    rd(12'hC00, d);
    chk(d[30] == 1'b1, "R10 request set", d[30], 1);
    @(negedge clk);
    rd(12'hC00, d);
    chk(d == cfg(1, 32, 0), "R10 committed next clock", d, cfg(1, 32, 0));

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule